// File: doc/BRIEF.md
# Pipeline Interstage Shadow Register File

This block keeps one shadow word for every link between adjacent stages of a five-stage pipeline (fetch, address compute, operand fetch, operate, store). Each link carries an opaque payload with a valid flag. When an enabled interrupt request arrives, the block takes a snapshot of all live link words in a single clock edge. In the next cycle it pulses a flush so the pipeline drops its in-flight slots, and it loads the program counter with a vector chosen by the winning request line.

A return command pulses a restore strobe for one cycle. During that strobe the pipeline reloads every link from the presented shadow bus, so the suspended instructions finish without a refill. Because the snapshot has no precise instruction boundary, supervisory code gets a read and write port for any shadow word. It can spill a snapshot to memory, take a nested interrupt after re-enabling, and later write the snapshot back before returning.

Top module: `pipe_shadow_file`

## Requirements
- R1: After synchronous active-low reset, every shadow word is zero, flush_o, pc_load_o and restore_o are low, pc_vector_o is zero, and interrupts are enabled.
- R2: There are four shadow words, indexed 0 to 3 from the fetch-side link to the store-side link. Word k of live_bus_i and restore_bus_o occupies bits [k*17 +: 17], with the valid flag in bit 16 of each word.
- R3: On a clock edge where interrupts are enabled and any irq_req bit is set, all four shadow words take the value of live_bus_i together.
- R4: flush_o is high for exactly the one cycle following the capture edge.
- R5: pc_load_o is high in that same cycle. pc_vector_o then equals 0x0100 + 16*i, where i is the lowest set index of irq_req at the capture edge, and it holds that value until the next capture.
- R6: From the capture edge on, interrupts stay masked. Requests have no effect (no flush, no PC load, shadows unchanged) until a return or an enable command is accepted.
- R7: When rti_i is high at an edge with no capture, restore_o is high for the next cycle, restore_bus_o presents the shadow words, and interrupts are re-enabled.
- R8: If a capture and rti_i coincide, the capture is performed, restore_o stays low, and interrupts stay masked.
- R9: When sw_we_i is high at an edge with no capture, shadow word sw_addr_i takes sw_wdata_i. sw_rdata_o shows shadow word sw_addr_i combinationally.
- R10: If a capture and a software write coincide, the capture sets all four words and the write is dropped.
- R11: int_en_set_i high at an edge with no capture re-enables interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 4 | Interrupt request lines, lowest index has priority |
| live_bus_i | input | 68 | Current contents of the four live link registers |
| rti_i | input | 1 | Return-from-interrupt command |
| int_en_set_i | input | 1 | Software re-enable of interrupts |
| sw_we_i | input | 1 | Supervisory write to a shadow word |
| sw_addr_i | input | 2 | Shadow word index for software read and write |
| sw_wdata_i | input | 17 | Supervisory write data |
| sw_rdata_o | output | 17 | Shadow word selected by sw_addr_i |
| flush_o | output | 1 | Invalidate all live pipeline slots |
| pc_load_o | output | 1 | Load PC from pc_vector_o |
| pc_vector_o | output | 16 | Interrupt vector address |
| restore_o | output | 1 | Reload live link registers from restore_bus_o |
| restore_bus_o | output | 68 | All four shadow words |

## Verification
A corrupted shadow word shows up on restore_bus_o in the cycle after the faulty edge, because the whole bank is exposed there at all times. A wrong enable state appears within one cycle of the next request, as a missing or extra flush and PC load. A wrong priority shows the same cycle as the PC load, as a bad vector. The random stream mixes requests, returns, enables and software writes, so coincident events occur often alongside the directed collisions.

// File: rtl/pshadow_pkg.sv
// Package: shared types for the interstage shadow register file.
// Assumes: one pulse set is produced per clock by the sequencer.
package pshadow_pkg;

    // One-cycle strobes issued to the pipeline after a sequencer decision
    typedef struct packed {
        logic flush;
        logic pc_load;
        logic restore;
    } seq_pulse_t;

endpackage

// File: rtl/pshadow_prio.sv
// Module: fixed-priority request picker; the lowest set index wins.
// Assumes: N >= 2, purely combinational.
module pshadow_prio #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set index is the last one written
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/pshadow_bank.sv
// Module: bank of shadow words, one per interstage link.
// Assumes: a capture overrides a software write in the same cycle.
module pshadow_bank #(
    parameter int NL = 4,
    parameter int WW = 17,
    localparam int AW = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [NL*WW-1:0] live_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WW-1:0]    wr_data_i,
    output logic [WW-1:0]    rd_data_o,
    output logic [NL*WW-1:0] shadow_o
);

    logic [WW-1:0] sh_q [NL];

    for (genvar g = 0; g < NL; g++) begin : g_word
        // Capture a link snapshot or accept a supervisory write
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_q[g] <= '0;
            else if (cap_i)
                sh_q[g] <= live_i[g*WW +: WW];
            else if (wr_en_i && addr_i == AW'(g))
                sh_q[g] <= wr_data_i;
        end

        assign shadow_o[g*WW +: WW] = sh_q[g];

        AST_SW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !cap_i && addr_i == AW'(g)) |=> sh_q[g] == $past(wr_data_i)); // R9
    end

    // Supervisory read of the addressed word
    always_comb rd_data_o = sh_q[addr_i];

    AST_CAPTURE_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> shadow_o == $past(live_i)); // R3

endmodule

// File: rtl/pshadow_seq.sv
// Module: interrupt sequencer; owns the enable flag, the pulses and the vector.
// Assumes: capture takes priority over return and enable commands.
module pshadow_seq
    import pshadow_pkg::*;
#(
    parameter int          N         = 4,
    parameter int          PC_W      = 16,
    parameter logic [15:0] VEC_BASE  = 16'h0100,
    parameter int          VEC_SHIFT = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_req_i,
    input  logic [IW-1:0]   req_idx_i,
    input  logic            rti_i,
    input  logic            en_set_i,
    output logic            cap_o,
    output seq_pulse_t      pulse_o,
    output logic [PC_W-1:0] vector_o
);

    logic en_q;

    // A request is taken only while interrupts are enabled
    always_comb cap_o = en_q && any_req_i;

    // Enable flag: cleared on capture, set by return or software
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b1;
        else if (cap_o)
            en_q <= 1'b0;
        else if (rti_i || en_set_i)
            en_q <= 1'b1;
    end

    // One-cycle strobes toward the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_o <= '0;
        else begin
            pulse_o.flush   <= cap_o;
            pulse_o.pc_load <= cap_o;
            pulse_o.restore <= rti_i && !cap_o;
        end
    end

    // Vector register, updated only on capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            vector_o <= '0;
        else if (cap_o)
            vector_o <= PC_W'(VEC_BASE) + (PC_W'(req_idx_i) << VEC_SHIFT);
    end

    AST_MASK_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o.pc_load |=> !pulse_o.pc_load); // R6
    AST_CAPTURE_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o && rti_i) |=> (!pulse_o.restore && !en_q)); // R8
    AST_NO_RESTORE_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_o.restore && pulse_o.flush)); // R8
    AST_RETURN_REENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o.restore |-> en_q); // R7

endmodule

// File: rtl/pipe_shadow_file.sv
// Module: top of the interstage shadow register file.
// Assumes: the pipeline honours flush_o, pc_load_o and restore_o in the cycle they are high.
module pipe_shadow_file
    import pshadow_pkg::*;
#(
    parameter int          NUM_STAGES = 5,
    parameter int          PAYLOAD_W  = 16,
    parameter int          NUM_REQ    = 4,
    parameter int          PC_W       = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0100,
    parameter int          VEC_SHIFT  = 4,
    localparam int NL = NUM_STAGES - 1,
    localparam int WW = PAYLOAD_W + 1,
    localparam int AW = $clog2(NL),
    localparam int IW = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] irq_req,
    input  logic [NL*WW-1:0]   live_bus_i,
    input  logic               rti_i,
    input  logic               int_en_set_i,
    input  logic               sw_we_i,
    input  logic [AW-1:0]      sw_addr_i,
    input  logic [WW-1:0]      sw_wdata_i,
    output logic [WW-1:0]      sw_rdata_o,
    output logic               flush_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_vector_o,
    output logic               restore_o,
    output logic [NL*WW-1:0]   restore_bus_o
);

    logic          sel_any;
    logic [IW-1:0] sel_idx;
    logic          cap;
    seq_pulse_t    pulse;

    pshadow_prio #(.N(NUM_REQ)) u_prio (
        .req (irq_req),
        .any (sel_any),
        .idx (sel_idx)
    );

    pshadow_seq #(
        .N(NUM_REQ), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req_i (sel_any),
        .req_idx_i (sel_idx),
        .rti_i     (rti_i),
        .en_set_i  (int_en_set_i),
        .cap_o     (cap),
        .pulse_o   (pulse),
        .vector_o  (pc_vector_o)
    );

    pshadow_bank #(.NL(NL), .WW(WW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .live_i    (live_bus_i),
        .wr_en_i   (sw_we_i),
        .addr_i    (sw_addr_i),
        .wr_data_i (sw_wdata_i),
        .rd_data_o (sw_rdata_o),
        .shadow_o  (restore_bus_o)
    );

    // Drive the pipeline strobes from the sequencer pulses
    always_comb begin
        flush_o   = pulse.flush;
        pc_load_o = pulse.pc_load;
        restore_o = pulse.restore;
    end

    AST_PICK_IS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> irq_req[sel_idx]); // R5
    AST_PICK_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        sel_any |-> ((irq_req & ((NUM_REQ'(1) << sel_idx) - NUM_REQ'(1))) == '0)); // R5
    AST_VECTOR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load_o |-> $stable(pc_vector_o)); // R5
    AST_FLUSH_PAIRS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (pc_load_o && !restore_o)); // R4

endmodule

// File: tb/test_pipe_shadow_file.sv
module test_pipe_shadow_file;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 17;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    irq_req = '0;
    logic [67:0]   live_bus_i = '0;
    logic          rti_i = 1'b0;
    logic          int_en_set_i = 1'b0;
    logic          sw_we_i = 1'b0;
    logic [1:0]    sw_addr_i = '0;
    logic [16:0]   sw_wdata_i = '0;
    logic [16:0]   sw_rdata_o;
    logic          flush_o;
    logic          pc_load_o;
    logic [15:0]   pc_vector_o;
    logic          restore_o;
    logic [67:0]   restore_bus_o;

    int errors = 0;
    int checks = 0;

    // Reference model state
    logic [16:0] m_sh [NL];
    logic        m_en;
    logic        e_flush, e_pc, e_rst;
    logic [15:0] e_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_shadow_file i_pipe_shadow_file (
        .clk, .rst_n, .irq_req, .live_bus_i, .rti_i, .int_en_set_i,
        .sw_we_i, .sw_addr_i, .sw_wdata_i, .sw_rdata_o, .flush_o,
        .pc_load_o, .pc_vector_o, .restore_o, .restore_bus_o
    );

    function automatic logic [15:0] vec_of(input logic [3:0] r);
        for (int i = 0; i < 4; i++)
            if (r[i]) return 16'h0100 + 16'(16 * i);
        return 16'h0;
    endfunction

    function automatic logic [67:0] pack_model();
        logic [67:0] v;
        for (int k = 0; k < NL; k++) v[k*WW +: WW] = m_sh[k];
        return v;
    endfunction

    task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a negedge, step the model, compare at the next negedge
    task automatic do_cycle(input logic [3:0] irq, input logic rti, input logic ens,
                            input logic we, input logic [1:0] a, input logic [16:0] wd,
                            input logic [67:0] live);
        logic cap;
        irq_req = irq; rti_i = rti; int_en_set_i = ens;
        sw_we_i = we; sw_addr_i = a; sw_wdata_i = wd; live_bus_i = live;
        #1;
        check("R9 read", 68'(sw_rdata_o), 68'(m_sh[a]));
        cap = m_en && (|irq);
        if (cap) begin
            for (int k = 0; k < NL; k++) m_sh[k] = live[k*WW +: WW];
            e_vec = vec_of(irq);
            m_en = 1'b0;
        end else begin
            if (we) m_sh[a] = wd;
            if (rti || ens) m_en = 1'b1;
        end
        e_flush = cap; e_pc = cap; e_rst = rti && !cap;
        @(posedge clk);
        @(negedge clk);
        check("R4 flush", 68'(flush_o), 68'(e_flush));
        check("R5 pc_load", 68'(pc_load_o), 68'(e_pc));
        check("R5 vector", 68'(pc_vector_o), 68'(e_vec));
        check("R7 restore", 68'(restore_o), 68'(e_rst));
        check("R3 shadow bus", restore_bus_o, pack_model());
    endtask

    function automatic logic [67:0] rnd68();
        return {4'($urandom), $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [67:0] l1;
        process::self().srandom(32'h5eed_1234);
        for (int k = 0; k < NL; k++) m_sh[k] = '0;
        m_en = 1'b1; e_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 flush", 68'(flush_o), 68'(0));
        check("R1 pc_load", 68'(pc_load_o), 68'(0));
        check("R1 restore", 68'(restore_o), 68'(0));
        check("R1 vector", 68'(pc_vector_o), 68'(0));
        check("R1 shadows", restore_bus_o, 68'(0));

        // R1/R5: enabled out of reset, index 1 wins over 3
        l1 = {17'h1_AAAA, 17'h0_5555, 17'h1_0F0F, 17'h1_1234};
        do_cycle(4'b1010, 0, 0, 0, 0, 0, l1);
        check("R1 enabled", 68'(pc_load_o), 68'(1));
        check("R5 vector idx1", 68'(pc_vector_o), 68'(16'h0110));
        // R2: word layout through the read port
        for (int k = 0; k < NL; k++) begin
            sw_addr_i = 2'(k);
            #1;
            check("R2 layout", 68'(sw_rdata_o), 68'(l1[k*WW +: WW]));
        end
        // R6: masked request ignored
        do_cycle(4'b0001, 0, 0, 0, 0, 0, rnd68());
        check("R6 no flush", 68'(flush_o), 68'(0));
        check("R6 shadows kept", restore_bus_o, l1);
        // R9: software write
        do_cycle(0, 0, 0, 1, 2'd2, 17'h1_BEEF, rnd68());
        // R7: return
        do_cycle(0, 1, 0, 0, 0, 0, rnd68());
        check("R7 restore", 68'(restore_o), 68'(1));
        // R8: capture and return together
        do_cycle(4'b1000, 1, 0, 0, 0, 0, rnd68());
        check("R8 no restore", 68'(restore_o), 68'(0));
        check("R8 vector idx3", 68'(pc_vector_o), 68'(16'h0130));
        do_cycle(4'b0001, 0, 0, 0, 0, 0, rnd68());
        check("R8 still masked", 68'(pc_load_o), 68'(0));
        // R11: software enable, then R10: capture with a write
        do_cycle(0, 0, 1, 0, 0, 0, rnd68());
        l1 = rnd68();
        do_cycle(4'b0100, 0, 0, 1, 2'd0, 17'h0_0001, l1);
        check("R11 re-enabled", 68'(pc_load_o), 68'(1));
        check("R10 capture wins", restore_bus_o, l1);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            do_cycle(($urandom % 6 == 0) ? 4'($urandom) : 4'h0,
                     ($urandom % 8 == 0), ($urandom % 16 == 0),
                     ($urandom % 3 == 0), 2'($urandom), 17'($urandom), rnd68());
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule